// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a two-wire bus target that lets a host controller read and write a small bank of 8-bit configuration registers. SCL and SDA are sampled with the system clock through synchronizers. The target pulls SDA low through an open-drain enable and never drives it high.

A write transfer has three parts. The host first sends the device address with the direction bit clear. It then sends a register index. Each data byte after that lands at the current index, and the index then advances by one.

A read uses the same index pointer. The usual way to start one is to send the index, issue a repeated START, and send the device address with the direction bit set. The target then returns registers in ascending order for as long as the host acknowledges.

The target enforces three firm rules. An index outside the register map is refused. Writing past the top of the map ends the transfer. Reading past the top keeps returning the top register. Other on-chip logic can read any register at any time through a combinational side port.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset the SDA pull enable is 0 and every register reads 0x00 on the side port.
- R2: The write address byte is 0xD4 when `addr_strap` is 0 and 0xD6 when it is 1. This is the 7-bit address {110101, strap} followed by a direction bit, where 0 means write and 1 means read. A matching address is acknowledged by holding SDA low during the ninth SCL pulse. Any other address gets no acknowledge, and the target ignores all later bytes until the next START.
- R3: Bytes are sent MSB first. In a write, the byte after the address is the register index (valid range 0x00 to 0x0F). Each later data byte is stored at the current index and acknowledged, and the index then increments by one.
- R4: An index byte of 0x10 or above is not acknowledged. The target returns to idle, so later data bytes are not acknowledged and no register changes.
- R5: A data byte written after register 0x0F has been filled is not stored and is not acknowledged. The target returns to idle, and the index does not wrap to 0x00.
- R6: A read transfer returns the register at the stored index, MSB first, and advances the index after each acknowledge from the host.
- R7: A read that continues past index 0x0F returns the contents of register 0x0F for every further byte.
- R8: When the host does not acknowledge a read byte, the target releases SDA and goes idle. A byte clocked after that without a new START reads 0xFF.
- R9: A STOP at any point returns the target to idle. A START at any point, including partway through a byte, restarts address reception, and a partly received byte is discarded.
- R10: The SDA pull enable changes only while SCL is low.
- R11: `rd_data` always shows the register selected by `rd_idx`, including a value written by a bus transfer that has just finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, sampled |
| sda_in | input | 1 | Bus data line, sampled |
| addr_strap | input | 1 | Selects the low bit of the 7-bit device address |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| rd_idx | input | 4 | Side port register index |
| rd_data | output | 8 | Side port register contents |

## Verification
Most wrong internal states show on the ninth SCL pulse of the byte being handled. A bad bit count, a bad address compare or a bad index check turns an acknowledge into a missing one, or the reverse, within that one byte. A wrong index pointer or a wrong write strobe does not show on the bus until later. It shows on the side port a few system clocks after the acknowledge, or in the first byte of the next read, which returns the wrong register. A missed STOP or START leaves the target acknowledging bytes it should ignore, so the bench follows each of these events with a byte that must not be acknowledged.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int unsigned CFG_REGS = 16;
  localparam int unsigned CFG_DW   = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_state_e;

  // device address compare: upper six bits fixed, lowest from the strap
  function automatic logic addr_hit(input logic [6:0] a7, input logic [5:0] hi,
                                    input logic strap);
    return a7 == {hi, strap};
  endfunction

  // index byte lies inside the map
  function automatic logic index_ok(input logic [7:0] b, input int unsigned regs);
    return int'(b) < int'(regs);
  endfunction
endpackage

// File: rtl/cfg_i2c_linesync.sv
module cfg_i2c_linesync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  assign scl_s     = synced[1];
  assign sda_s     = synced[0];
  assign scl_rise  = synced[1] & ~prev[1];
  assign scl_fall  = ~synced[1] & prev[1];
  assign start_det = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_det  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile #(
  parameter int unsigned REGS = 16,
  parameter int unsigned DW   = 8,
  localparam int unsigned IDX_W = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] fa_idx,
  output logic [DW-1:0]    fa_data,
  input  logic [IDX_W-1:0] sb_idx,
  output logic [DW-1:0]    sb_data
);
  logic [DW-1:0] mem [REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(REGS); i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign fa_data = mem[fa_idx];
  assign sb_data = mem[sb_idx];

  // R3
  store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned REGS = 16,
  parameter int unsigned DW   = 8,
  parameter logic [5:0]  DEV_HI = 6'b110101,
  localparam int unsigned IDX_W = $clog2(REGS),
  localparam int unsigned PTR_W = IDX_W + 1,
  localparam int unsigned CNT_W = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             strap,
  output logic [IDX_W-1:0] fetch_idx,
  input  logic [DW-1:0]    fetch_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             sda_pull
);
  bus_state_e       state;
  logic [CNT_W-1:0] bitcnt;
  logic [DW-1:0]    rx_sh;
  logic [DW-1:0]    tx_sh;
  logic [PTR_W-1:0] ptr;
  logic             pull_q;
  logic             dir_rd;
  logic             host_ack;

  // pointer arithmetic: saturates one past the top, reads clamp to the top
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(REGS)) ? p : p + PTR_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] ptr_clamp(input logic [PTR_W-1:0] p);
    return (p >= PTR_W'(REGS)) ? IDX_W'(REGS - 1) : p[IDX_W-1:0];
  endfunction

  // named internal events
  logic quiet, byte_done, byte_end, addr_take, sub_take, sub_reject;
  logic wr_take, wr_reject, rd_end, rd_next;

  assign quiet      = !start_det && !stop_det;
  assign byte_done  = (bitcnt == CNT_W'(DW));
  assign byte_end   = quiet && scl_fall && byte_done;
  assign addr_take  = byte_end && (state == ST_ADDR) && addr_hit(rx_sh[DW-1:1], DEV_HI, strap);
  assign sub_take   = byte_end && (state == ST_SUB) && index_ok(rx_sh, REGS);
  assign sub_reject = byte_end && (state == ST_SUB) && !index_ok(rx_sh, REGS);
  assign wr_take    = byte_end && (state == ST_WR) && (ptr < PTR_W'(REGS));
  assign wr_reject  = byte_end && (state == ST_WR) && !(ptr < PTR_W'(REGS));
  assign rd_end     = quiet && scl_fall && (state == ST_RD_ACK) && !host_ack;
  assign rd_next    = quiet && scl_fall && (state == ST_RD_ACK) && host_ack;

  assign fetch_idx = (state == ST_RD_ACK) ? ptr_clamp(ptr_step(ptr)) : ptr_clamp(ptr);
  assign wr_en     = wr_take;
  assign wr_idx    = ptr[IDX_W-1:0];
  assign wr_data   = rx_sh;
  assign sda_pull  = pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      pull_q   <= 1'b0;
      dir_rd   <= 1'b0;
      host_ack <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      pull_q <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      pull_q <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (scl_rise && !byte_done) begin
            rx_sh  <= {rx_sh[DW-2:0], sda_s};
            bitcnt <= bitcnt + CNT_W'(1);
          end
          if (scl_fall && byte_done) begin
            bitcnt <= '0;
            if (addr_take) begin
              state  <= ST_ADDR_ACK;
              pull_q <= 1'b1;
              dir_rd <= rx_sh[0];
            end else if (sub_take) begin
              state  <= ST_SUB_ACK;
              pull_q <= 1'b1;
              ptr    <= {1'b0, rx_sh[IDX_W-1:0]};
            end else if (wr_take) begin
              state  <= ST_WR_ACK;
              pull_q <= 1'b1;
              ptr    <= ptr_step(ptr);
            end else begin
              state  <= ST_IDLE;
              pull_q <= 1'b0;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (dir_rd) begin
              state  <= ST_RD;
              tx_sh  <= fetch_data;
              pull_q <= ~fetch_data[DW-1];
            end else begin
              state  <= ST_SUB;
              pull_q <= 1'b0;
            end
          end
        end
        ST_SUB_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            state  <= ST_WR;
            bitcnt <= '0;
            pull_q <= 1'b0;
          end
        end
        ST_RD: begin
          if (scl_rise) bitcnt <= bitcnt + CNT_W'(1);
          if (scl_fall) begin
            if (byte_done) begin
              state  <= ST_RD_ACK;
              pull_q <= 1'b0;
            end else begin
              tx_sh  <= {tx_sh[DW-2:0], 1'b0};
              pull_q <= ~tx_sh[DW-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) host_ack <= ~sda_s;
          if (rd_next) begin
            state  <= ST_RD;
            bitcnt <= '0;
            ptr    <= ptr_step(ptr);
            tx_sh  <= fetch_data;
            pull_q <= ~fetch_data[DW-1];
          end else if (rd_end) begin
            state  <= ST_IDLE;
            pull_q <= 1'b0;
          end
        end
        default: begin
          state  <= ST_IDLE;
          pull_q <= 1'b0;
        end
      endcase
    end
  end

  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_s);

  // R9
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_pull);

  // R9
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_ADDR));

  // R4
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_reject |=> (state == ST_IDLE) && !sda_pull);

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> (state == ST_IDLE) && !sda_pull && $stable(ptr));

  // R8
  host_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> (state == ST_IDLE) && !sda_pull);
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned REGS   = CFG_REGS,
  parameter int unsigned DW     = CFG_DW,
  parameter int unsigned STAGES = 2,
  parameter logic [5:0]  DEV_HI = 6'b110101,
  localparam int unsigned IDX_W = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             addr_strap,
  output logic             sda_pull,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, fetch_idx;
  logic [DW-1:0]    wr_data, fetch_data;

  cfg_i2c_linesync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfg_i2c_engine #(.REGS(REGS), .DW(DW), .DEV_HI(DEV_HI)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .strap(addr_strap),
    .fetch_idx(fetch_idx), .fetch_data(fetch_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_pull(sda_pull)
  );

  cfg_i2c_regfile #(.REGS(REGS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .fa_idx(fetch_idx), .fa_data(fetch_data), .sb_idx(rd_idx), .sb_data(rd_data)
  );
endmodule

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  cfg_i2c_target i_cfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_strap(strap), .sda_pull(sda_pull), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  typedef struct { string tag; int val; } exp_t;
  exp_t exp_q[$];
  int   act_q[$];
  int   compared = 0;
  int   mismatched = 0;
  int   pull_bad = 0;
  logic pull_prev = 1'b0;
  bit   done = 1'b0;

  // scoreboard monitor
  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      exp_t e;
      int a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      compared++;
      if (a != e.val) begin
        mismatched++;
        $display("FAIL %s actual=%0h expected=%0h", e.tag, a, e.val);
      end
    end
  end

  // R10: pull enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && (sda_pull !== pull_prev) && scl_m) pull_bad++;
    pull_prev = sda_pull;
  end

  task automatic want(input string tag, input int v);
    exp_q.push_back('{tag, v});
  endtask

  task automatic got(input int v);
    act_q.push_back(v);
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    hold(2); sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H);
    sda_m = 1'b0; hold(H); scl_m = 1'b0; hold(H);
  endtask

  task automatic bus_stop();
    hold(2); sda_m = 1'b0; hold(H); scl_m = 1'b1; hold(H); sda_m = 1'b1; hold(H);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    hold(2); sda_m = b; hold(H - 2); scl_m = 1'b1; hold(H);
    s = sda_line; scl_m = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
  endtask

  task automatic wbyte(input string tag, input logic [7:0] b, input bit exp_ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    want(tag, exp_ack);
    got(!s);
  endtask

  task automatic rbyte(input string tag, input logic [7:0] expv, input bit give_ack);
    logic s;
    logic [7:0] d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(!give_ack, s);
    want(tag, expv);
    got(d);
  endtask

  task automatic reg_is(input string tag, input int idx, input logic [7:0] v);
    rd_idx = idx[3:0];
    @(negedge clk);
    want(tag, v);
    got(rd_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    hold(5);
    rst_n = 1'b1;
    hold(5);
    // R1 reset state
    want("R1 pull after reset", 0); got(sda_pull);
    reg_is("R1 reg0 reset", 0, 8'h00);
    reg_is("R1 reg15 reset", 15, 8'h00);

    // R2 R3 write with strap 0
    bus_start();
    wbyte("R2 address 0xD4 ack", 8'hD4, 1);
    wbyte("R3 index 0x02 ack", 8'h02, 1);
    wbyte("R3 data A5 ack", 8'hA5, 1);
    wbyte("R3 data 3C ack", 8'h3C, 1);
    bus_stop();
    reg_is("R3 R11 reg2", 2, 8'hA5);
    reg_is("R3 R11 reg3", 3, 8'h3C);

    // R2 wrong address stays silent until next START
    bus_start();
    wbyte("R2 address 0xD6 refused with strap 0", 8'hD6, 0);
    wbyte("R2 later byte ignored", 8'h00, 0);
    bus_stop();
    reg_is("R2 reg0 untouched", 0, 8'h00);

    // R5 overrun with strap 1
    strap = 1'b1;
    bus_start();
    wbyte("R2 address 0xD6 ack with strap 1", 8'hD6, 1);
    wbyte("R3 index 0x0E ack", 8'h0E, 1);
    wbyte("R3 data 11 ack", 8'h11, 1);
    wbyte("R3 data 22 ack", 8'h22, 1);
    wbyte("R5 overrun byte nack", 8'h33, 0);
    wbyte("R5 idle after overrun", 8'h44, 0);
    bus_stop();
    reg_is("R5 reg14", 14, 8'h11);
    reg_is("R5 reg15 kept", 15, 8'h22);
    reg_is("R5 no wrap reg0", 0, 8'h00);

    // R4 invalid index
    bus_start();
    wbyte("R4 address ack", 8'hD6, 1);
    wbyte("R4 index 0x10 nack", 8'h10, 0);
    wbyte("R4 data after bad index nack", 8'h77, 0);
    bus_stop();
    reg_is("R4 reg0 untouched", 0, 8'h00);

    // R6 R8 read after pointer write
    bus_start();
    wbyte("R6 address ack", 8'hD6, 1);
    wbyte("R6 index 0x02 ack", 8'h02, 1);
    bus_start();
    wbyte("R6 read address ack", 8'hD7, 1);
    rbyte("R6 read reg2", 8'hA5, 1);
    rbyte("R6 read reg3", 8'h3C, 1);
    rbyte("R6 R8 read reg4 then nack", 8'h00, 0);
    rbyte("R8 released line reads FF", 8'hFF, 0);
    bus_stop();

    // R7 read past the top
    bus_start();
    wbyte("R7 address ack", 8'hD6, 1);
    wbyte("R7 index 0x0E ack", 8'h0E, 1);
    bus_start();
    wbyte("R7 read address ack", 8'hD7, 1);
    rbyte("R7 reg14", 8'h11, 1);
    rbyte("R7 reg15", 8'h22, 1);
    rbyte("R7 top repeated", 8'h22, 1);
    rbyte("R7 top repeated again", 8'h22, 0);
    bus_stop();

    // R9 STOP partway through a data byte
    bus_start();
    wbyte("R9 address ack", 8'hD6, 1);
    wbyte("R9 index 0x05 ack", 8'h05, 1);
    wbyte("R9 data 5A ack", 8'h5A, 1);
    send_bits(8'hF0, 4);
    bus_stop();
    wbyte("R9 byte after STOP ignored", 8'h99, 0);
    reg_is("R9 reg5", 5, 8'h5A);
    reg_is("R9 reg6 partial dropped", 6, 8'h00);

    // R9 START partway through a data byte
    bus_start();
    wbyte("R9 address ack 2", 8'hD6, 1);
    wbyte("R9 index 0x07 ack", 8'h07, 1);
    send_bits(8'hE0, 3);
    bus_start();
    wbyte("R9 address after restart ack", 8'hD6, 1);
    wbyte("R9 index 0x08 ack", 8'h08, 1);
    wbyte("R9 data 66 ack", 8'h66, 1);
    bus_stop();
    reg_is("R9 reg7 partial dropped", 7, 8'h00);
    reg_is("R9 R11 reg8", 8, 8'h66);

    // R10 pull enable moved only with SCL low
    want("R10 pull changes while SCL high", 0); got(pull_bad);

    hold(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule